// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address of every beat of a single memory read or write burst. The caller presents a starting column, a length flag (four or eight beats) and an ordering flag (sequential or interleaved) with a one-cycle start pulse. From the next clock onward, the block emits one column address per clock with a valid flag, and it marks the final beat with a last flag.

Every beat of a burst stays inside an aligned block whose size equals the burst length. Column bits above that block are carried through unchanged. The bits inside the block follow an order set jointly by the length, the ordering and the starting offset. For eight-beat sequential bursts the order is nibble based: the low two bits count modulo four, and bit 2 toggles for the second half of the burst.

A busy output tells the caller when a new burst may be requested. A start pulse that arrives while a burst is running is dropped, and it is flagged for one cycle so the caller can detect the broken back-to-back rule.

Top module: `burst_colseq`

## Requirements
- R1: After reset, `beat_valid`, `beat_last`, `busy` and `start_err` are all low.
- R2: A `start` seen at a rising edge while `busy` is low produces the first beat on the following cycle, and that beat's column equals the sampled `start_col`.
- R3: An accepted burst emits exactly 4 beats when `len8`=0 or 8 beats when `len8`=1, on consecutive clocks with no gap.
- R4: `beat_last` is high together with the final beat's address and on no other beat, and `beat_valid` is low on the cycle after it.
- R5: With `interleave`=1, the low bits of beat i equal the starting low bits XOR i. This covers bits [2:0] for 8 beats and bits [1:0] for 4 beats.
- R6: With `interleave`=0 and `len8`=0, bits [1:0] of beat i equal (start[1:0] + i) mod 4.
- R7: With `interleave`=0 and `len8`=1, bits [1:0] of beat i equal (start[1:0] + i) mod 4. Bit 2 equals start[2] for beats 0 to 3 and its inverse for beats 4 to 7. For example, a start offset of 1 gives 1,2,3,0,5,6,7,4.
- R8: The column bits above the block stay equal to the starting column for the whole burst. These are bits [COL_W-1:2] for 4 beats and bits [COL_W-1:3] for 8 beats.
- R9: A `start` seen at a rising edge while `busy` is high is ignored and sets `start_err` high for exactly the next cycle. The burst in progress continues unchanged.
- R10: `busy` is high from the first beat through the last beat and low otherwise. This includes the last-beat cycle, so a start on that cycle is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Burst request pulse |
| start_col | input | COL_W | Starting column address |
| len8 | input | 1 | 1 selects 8 beats, 0 selects 4 beats |
| interleave | input | 1 | 1 selects interleaved order, 0 selects sequential |
| beat_valid | output | 1 | A beat address is present |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| busy | output | 1 | A burst is in progress |
| start_err | output | 1 | One-cycle flag for a start dropped while busy |

## Verification
The assertions assume that `start_col`, `len8` and `interleave` are sampled only on the edge where `start` is accepted, and that reset is held for at least one edge. They make no assumption about how often `start` is asserted, because requests made while busy are legal and are flagged. The stimulus draws random columns, lengths, orders and idle gaps from a seeded generator. It also issues start pulses during random beats of a running burst, including the last beat, and it adds directed cases for the nibble-wrap example and for the offsets at each block edge.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  // Index of the final beat for the selected length.
  function automatic logic [2:0] final_idx(input logic len8);
    return len8 ? 3'd7 : 3'd3;
  endfunction

  // Low three column bits of beat i, given the starting low bits s.
  function automatic logic [2:0] beat_low(input logic [2:0] s,
                                          input logic [2:0] i,
                                          input logic len8,
                                          input order_e ord);
    logic [2:0] r;
    if (ord == ORD_ILV) begin
      r = s ^ {len8 & i[2], i[1:0]};
    end else begin
      r = {s[2] ^ (len8 & i[2]), s[1:0] + i[1:0]};
    end
    return r;
  endfunction

endpackage

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
  import colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             len8,
  input  order_e           ord,
  output logic             act,
  output logic [2:0]       idx,
  output logic [COL_W-1:0] col_q,
  output logic             len8_q,
  output order_e           ord_q,
  output logic             at_end,
  output logic             err
);

  logic accept;
  logic reject;

  assign accept = start && !act;
  assign reject = start && act;
  assign at_end = act && (idx == final_idx(len8_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      idx    <= '0;
      col_q  <= '0;
      len8_q <= 1'b0;
      ord_q  <= ORD_SEQ;
      err    <= 1'b0;
    end else begin
      err <= reject;
      if (accept) begin
        act    <= 1'b1;
        idx    <= '0;
        col_q  <= start_col;
        len8_q <= len8;
        ord_q  <= ord;
      end else if (act) begin
        if (at_end) begin
          act <= 1'b0;
        end else begin
          idx <= idx + 3'd1;
        end
      end
    end
  end

  // R9: a request made while busy is flagged on the next cycle
  assert_reject_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err);

  // R9: an accepted request never raises the error flag
  assert_accept_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !err);

  // R3: beat index never passes the final beat
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> idx <= final_idx(len8_q));

  // R3: index steps by one between beats of a burst
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act && !at_end |=> idx == $past(idx) + 3'd1);

endmodule

// File: rtl/colseq_addr.sv
module colseq_addr
  import colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] col_q,
  input  logic [2:0]       idx,
  input  logic             len8_q,
  input  order_e           ord_q,
  output logic [COL_W-1:0] col_out
);

  localparam int HI_W = COL_W - 3;

  logic [2:0] low;

  always_comb begin
    low = beat_low(col_q[2:0], idx, len8_q, ord_q);
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign col_out = {col_q[COL_W-1:3], low};
    end else begin : g_nohi
      assign col_out = low[COL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             len8,
  input  logic             interleave,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             busy,
  output logic             start_err
);

  logic             act;
  logic [2:0]       idx;
  logic [COL_W-1:0] col_q;
  logic             len8_q;
  order_e           ord_q;
  logic             at_end;
  order_e           ord_in;

  assign ord_in = order_e'(interleave);

  colseq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .len8      (len8),
    .ord       (ord_in),
    .act       (act),
    .idx       (idx),
    .col_q     (col_q),
    .len8_q    (len8_q),
    .ord_q     (ord_q),
    .at_end    (at_end),
    .err       (start_err)
  );

  colseq_addr #(.COL_W(COL_W)) u_addr (
    .col_q   (col_q),
    .idx     (idx),
    .len8_q  (len8_q),
    .ord_q   (ord_q),
    .col_out (beat_col)
  );

  assign beat_valid = act;
  assign beat_last  = at_end;
  assign busy       = act;

  // R2: first beat appears next cycle carrying the requested column
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> beat_valid && beat_col == $past(start_col));

  // R3: beats run on consecutive clocks until the last one
  assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> beat_valid);

  // R4: the burst ends right after the last beat
  assert_last_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !beat_valid);

  // R4: last flag only with a valid beat
  assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  // R8: bits above the widest block hold across a burst
  assert_hi_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |-> beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3]));

  // R10: busy tracks beat activity
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy == beat_valid);

endmodule

// File: tb/burst_colseq_test.sv
module burst_colseq_test;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             len8 = 1'b0;
  logic             interleave = 1'b0;
  logic             beat_valid;
  logic [COL_W-1:0] beat_col;
  logic             beat_last;
  logic             busy;
  logic             start_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_colseq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len8(len8), .interleave(interleave), .beat_valid(beat_valid),
    .beat_col(beat_col), .beat_last(beat_last), .busy(busy),
    .start_err(start_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected column of beat i, worked out arithmetically from R5..R8
  function automatic int expect_col(input int col, input bit l8, input bit ilv, input int i);
    int lo, nib, half, blk;
    blk = l8 ? 8 : 4;
    lo  = col % blk;
    if (ilv) begin
      lo = lo ^ i;
    end else begin
      nib  = ((col % 4) + (i % 4)) % 4;
      half = l8 ? (((col / 4) % 2 + i / 4) % 2) : 0;
      lo   = half * 4 + nib;
    end
    return (col / blk) * blk + lo;
  endfunction

  // One burst; inj is the beat index during which a stray start is raised (-1 none)
  task automatic run_burst(input int col, input bit l8, input bit ilv, input int inj);
    int n;
    n = l8 ? 8 : 4;
    @(negedge clk);
    start = 1'b1; start_col = col[COL_W-1:0]; len8 = l8; interleave = ilv;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      check(beat_valid == 1'b1, "R3 valid", int'(beat_valid), 1);
      check(int'(beat_col) == expect_col(col, l8, ilv, i),
            ilv ? "R5 interleave order" : (l8 ? "R7 nibble order" : "R6 seq order"),
            int'(beat_col), expect_col(col, l8, ilv, i));
      check(beat_last == (i == n - 1), "R4 last", int'(beat_last), int'(i == n - 1));
      check(busy == 1'b1, "R10 busy", int'(busy), 1);
      if (i > 0) check(start_err == (inj == i - 1), "R9 err", int'(start_err), int'(inj == i - 1));
      if (i == inj) begin
        start = 1'b1;
        start_col = COL_W'($urandom);
        len8 = ~l8;
        interleave = ~ilv;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(beat_valid == 1'b0, "R4 ends", int'(beat_valid), 0);
    check(busy == 1'b0, "R10 idle", int'(busy), 0);
    check(start_err == (inj == n - 1), "R9 err after last", int'(start_err), int'(inj == n - 1));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(beat_valid == 1'b0, "R1 valid", int'(beat_valid), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(start_err == 1'b0, "R1 err", int'(start_err), 0);
    check(beat_last == 1'b0, "R1 last", int'(beat_last), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_burst(1, 1'b1, 1'b0, -1);                 // R7 example 1,2,3,0,5,6,7,4
    run_burst(10'h3FF, 1'b1, 1'b0, -1);           // R7 top offset, R8 upper bits
    run_burst(10'h3FF, 1'b0, 1'b0, -1);           // R6 wrap at 4, R8
    run_burst(10'h155, 1'b1, 1'b1, -1);           // R5 full 3-bit XOR
    run_burst(10'h156, 1'b0, 1'b1, 2);            // R5 2-bit XOR, R9 mid-burst
    run_burst(10'h004, 1'b1, 1'b0, 7);            // R9/R10 start on last beat
    run_burst(10'h200, 1'b0, 1'b1, 0);            // R9 on first beat

    // Random mix
    for (int k = 0; k < 300; k++) begin
      int inj;
      bit l8;
      l8 = 1'($urandom);
      inj = ($urandom % 3 == 0) ? int'($urandom % (l8 ? 8 : 4)) : -1;
      run_burst(int'($urandom % (1 << COL_W)), l8, 1'($urandom), inj);
      repeat ($urandom % 3) @(negedge clk);
    end

    // R9: start ignored leaves no trace once idle after a stray pulse
    @(negedge clk);
    check(beat_valid == 1'b0, "R9 no stray burst", int'(beat_valid), 0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule